// File: doc/BRIEF.md
# Remote Terminal Command Responder

This block is the word-level sequencing logic of a remote terminal on a command/response serial bus. An upstream receiver has already demodulated the line. It hands over each decoded 16-bit command word with a one-cycle strobe, and each received data word with a separate strobe. The block compares the address field with the terminal's strapped address and recognises broadcast and mode code commands. It counts the data words that a transfer expects, and it tells a transmit side when to send the status word and when to send each data word.

The receive and transmit directions have different orders. For a receive transfer, the terminal takes all of the data words first and answers with its status word afterwards. For a transmit transfer, it sends its status word first and the data words after it. Broadcast commands are acted on but never answered, so that several terminals do not reply on the bus at once. A new command always takes precedence over a transfer that is still running.

Top module: `rt_responder`

## Requirements
- R1: Command word fields are: address in bits 15:11, direction in bit 10 (1 = terminal transmits, 0 = terminal receives), subaddress in bits 9:5, and word count or mode number in bits 4:0. A command whose address is neither `rt_addr` nor 31 is ignored: `busy`, `mode_cmd` and `bcast_cmd` read 0 in the next cycle, no request pulse follows, and later data strobes have no effect.
- R2: For a receive command to `rt_addr` with a subaddress other than 0 or 31, `status_req` pulses for one cycle in the cycle after the strobe of the last expected data word, and not earlier. The block then returns to idle.
- R3: For a transmit command to `rt_addr` with a subaddress other than 0 or 31, `status_req` pulses in the cycle after the command. Each `tx_done` that arrives while data words remain is followed one cycle later by a one-cycle `data_req` pulse, so there are N pulses in total. The `tx_done` that follows the Nth data word returns the block to idle with no pulse.
- R4: A word count field of 0 means 32 data words. Any other value N means N data words.
- R5: Address 31 is a broadcast. `bcast_cmd` reads 1 from the cycle after the command. A broadcast receive transfer counts its data words and finishes without any `status_req`. A broadcast transmit command that is not a mode code is ignored, as in R1.
- R6: A subaddress of 0 or 31 makes the command a mode code. `mode_cmd` reads 1 from the next cycle, no data words are counted, and `busy` stays 0. `status_req` pulses in the cycle after the command unless the command is a broadcast.
- R7: A `cmd_valid` that arrives during a transfer aborts that transfer and is decoded as a fresh command. The old transfer never produces its status word.
- R8: While reset is held and after it is released, `status_req`, `data_req`, `mode_cmd`, `bcast_cmd` and `busy` are 0.
- R9: `data_valid` and `tx_done` have no effect while the block is idle, and `tx_done` has no effect during a receive transfer.
- R10: `busy` is 1 from the cycle after an accepted data transfer command until the cycle after the transfer completes. `mode_cmd` and `bcast_cmd` keep their values until the next `cmd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rt_addr | input | 5 | Strapped terminal address |
| cmd_word | input | 16 | Decoded command word |
| cmd_valid | input | 1 | One-cycle strobe: cmd_word holds a command |
| data_valid | input | 1 | One-cycle strobe: a received data word has arrived |
| tx_done | input | 1 | One-cycle strobe: the transmit side has finished sending a word |
| status_req | output | 1 | One-cycle request to send the status word |
| data_req | output | 1 | One-cycle request to send the next data word |
| mode_cmd | output | 1 | The last accepted command was a mode code |
| bcast_cmd | output | 1 | The last accepted command was a broadcast |
| busy | output | 1 | A data transfer is in progress |

## Verification
Errors in the word counter or the state register show up as a misplaced request pulse. A count that is off by one moves `status_req` a cycle early or late after the receive strobes, and the transmit side gets one `data_req` too many or too few. The scoreboard pins each pulse to the exact cycle, so such an error shows within one cycle of the affected strobe. A broadcast or abort flag that is wrongly kept shows as a status pulse where none may appear, or as a missing one, in the cycle right after the command or the last data word. The flags and `busy` are compared in the cycle after every strobe.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 5;
  localparam int SUB_W  = 5;
  localparam int CNT_W  = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RX   = 2'd1,
    ST_TX   = 2'd2
  } rt_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              xmit;
    logic [SUB_W-1:0]  sub;
    logic [CNT_W-1:0]  cnt;
  } rt_cmd_t;
endpackage

// File: rtl/rt_cmd_decode.sv
module rt_cmd_decode
  import rt_pkg::*;
#(
  parameter int ADDR_W_P = ADDR_W,
  parameter int SUB_W_P  = SUB_W,
  parameter int CNT_W_P  = CNT_W,
  localparam int WORD_W_L = ADDR_W_P + 1 + SUB_W_P + CNT_W_P
) (
  input  logic [WORD_W_L-1:0] cmd_word,
  input  logic [ADDR_W_P-1:0] rt_addr,
  output logic                hit_own,
  output logic                hit_bcast,
  output logic                is_mode,
  output logic                is_xmit,
  output logic [CNT_W_P:0]    word_total
);
  localparam logic [ADDR_W_P-1:0] BCAST_ADDR = {ADDR_W_P{1'b1}};

  logic [ADDR_W_P-1:0] f_addr;
  logic [SUB_W_P-1:0]  f_sub;
  logic [CNT_W_P-1:0]  f_cnt;

  assign f_addr  = cmd_word[WORD_W_L-1 -: ADDR_W_P];
  assign is_xmit = cmd_word[SUB_W_P + CNT_W_P];
  assign f_sub   = cmd_word[CNT_W_P +: SUB_W_P];
  assign f_cnt   = cmd_word[CNT_W_P-1:0];

  assign hit_bcast = (f_addr == BCAST_ADDR);
  assign hit_own   = (f_addr == rt_addr);
  assign is_mode   = (f_sub == '0) || (f_sub == '1);

  always_comb begin
    if (f_cnt == '0) word_total = {1'b1, {CNT_W_P{1'b0}}};
    else             word_total = {1'b0, f_cnt};
  end
endmodule

// File: rtl/rt_word_counter.sv
module rt_word_counter #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          is_last,
  output logic          is_zero
);
  logic [CW-1:0] rem_q, rem_d;

  always_comb begin
    rem_d = rem_q;
    if (load)     rem_d = load_val;
    else if (dec) rem_d = rem_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rem_q <= '0;
    else if (load || dec) rem_q <= rem_d;
  end

  assign is_last = (rem_q == CW'(1));
  assign is_zero = (rem_q == '0);
endmodule

// File: rtl/rt_seq_fsm.sv
module rt_seq_fsm
  import rt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic hit_own,
  input  logic hit_bcast,
  input  logic is_mode,
  input  logic is_xmit,
  input  logic data_valid,
  input  logic tx_done,
  input  logic cnt_last,
  input  logic cnt_zero,
  output logic cnt_load,
  output logic cnt_dec,
  output logic status_req,
  output logic data_req,
  output logic mode_cmd,
  output logic bcast_cmd,
  output logic busy
);
  rt_state_e state_q, state_d;
  logic stat_q, stat_d, dreq_q, dreq_d, mode_q, mode_d, bc_q, bc_d;
  logic cmd_ok;

  // Broadcast transmit data transfers are not legal and are dropped.
  assign cmd_ok = (hit_own || hit_bcast) && !(hit_bcast && is_xmit && !is_mode);

  always_comb begin
    state_d  = state_q;
    stat_d   = 1'b0;
    dreq_d   = 1'b0;
    mode_d   = mode_q;
    bc_d     = bc_q;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    if (cmd_valid) begin
      mode_d  = cmd_ok && is_mode;
      bc_d    = cmd_ok && hit_bcast;
      state_d = ST_IDLE;
      stat_d  = cmd_ok && !hit_bcast && (is_mode || is_xmit);
      if (cmd_ok && !is_mode) begin
        state_d  = is_xmit ? ST_TX : ST_RX;
        cnt_load = 1'b1;
      end
    end else begin
      unique case (state_q)
        ST_RX: if (data_valid) begin
          if (cnt_last) begin
            stat_d  = !bc_q;
            state_d = ST_IDLE;
          end else begin
            cnt_dec = 1'b1;
          end
        end
        ST_TX: if (tx_done) begin
          if (cnt_zero) begin
            state_d = ST_IDLE;
          end else begin
            dreq_d  = 1'b1;
            cnt_dec = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      stat_q  <= 1'b0;
      dreq_q  <= 1'b0;
      mode_q  <= 1'b0;
      bc_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      stat_q  <= stat_d;
      dreq_q  <= dreq_d;
      if (cmd_valid) begin
        mode_q <= mode_d;
        bc_q   <= bc_d;
      end
    end
  end

  assign status_req = stat_q;
  assign data_req   = dreq_q;
  assign mode_cmd   = mode_q;
  assign bcast_cmd  = bc_q;
  assign busy       = (state_q != ST_IDLE);
endmodule

// File: rtl/rt_responder.sv
module rt_responder
  import rt_pkg::*;
#(
  parameter int ADDR_W_P = ADDR_W,
  parameter int SUB_W_P  = SUB_W,
  parameter int CNT_W_P  = CNT_W,
  localparam int WORD_W_L = ADDR_W_P + 1 + SUB_W_P + CNT_W_P
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W_P-1:0] rt_addr,
  input  logic [WORD_W_L-1:0] cmd_word,
  input  logic                cmd_valid,
  input  logic                data_valid,
  input  logic                tx_done,
  output logic                status_req,
  output logic                data_req,
  output logic                mode_cmd,
  output logic                bcast_cmd,
  output logic                busy
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic hit_own, hit_bcast, is_mode, is_xmit;
  logic [CNT_W_P:0] word_total;
  logic cnt_load, cnt_dec, cnt_last, cnt_zero;

  rt_cmd_decode #(
    .ADDR_W_P(ADDR_W_P), .SUB_W_P(SUB_W_P), .CNT_W_P(CNT_W_P)
  ) u_dec (
    .cmd_word  (cmd_word),
    .rt_addr   (rt_addr),
    .hit_own   (hit_own),
    .hit_bcast (hit_bcast),
    .is_mode   (is_mode),
    .is_xmit   (is_xmit),
    .word_total(word_total)
  );

  rt_word_counter #(.CW(CNT_W_P + 1)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (cnt_load),
    .load_val(word_total),
    .dec     (cnt_dec),
    .is_last (cnt_last),
    .is_zero (cnt_zero)
  );

  rt_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cmd_valid (cmd_valid),
    .hit_own   (hit_own),
    .hit_bcast (hit_bcast),
    .is_mode   (is_mode),
    .is_xmit   (is_xmit),
    .data_valid(data_valid),
    .tx_done   (tx_done),
    .cnt_last  (cnt_last),
    .cnt_zero  (cnt_zero),
    .cnt_load  (cnt_load),
    .cnt_dec   (cnt_dec),
    .status_req(status_req),
    .data_req  (data_req),
    .mode_cmd  (mode_cmd),
    .bcast_cmd (bcast_cmd),
    .busy      (busy)
  );
endmodule

// File: rtl/rt_responder_chk.sv
module rt_responder_chk #(
  parameter int ADDR_W_P = 5,
  parameter int SUB_W_P  = 5,
  parameter int CNT_W_P  = 5,
  localparam int WORD_W_L = ADDR_W_P + 1 + SUB_W_P + CNT_W_P
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W_P-1:0] rt_addr,
  input logic [WORD_W_L-1:0] cmd_word,
  input logic                cmd_valid,
  input logic                status_req,
  input logic                data_req,
  input logic                mode_cmd,
  input logic                bcast_cmd,
  input logic                busy
);
  logic [ADDR_W_P-1:0] c_addr;
  logic [SUB_W_P-1:0]  c_sub;
  logic                c_x, c_mode, c_foreign, c_own;

  assign c_addr    = cmd_word[WORD_W_L-1 -: ADDR_W_P];
  assign c_x       = cmd_word[SUB_W_P + CNT_W_P];
  assign c_sub     = cmd_word[CNT_W_P +: SUB_W_P];
  assign c_mode    = (c_sub == '0) || (c_sub == '1);
  assign c_foreign = (c_addr != rt_addr) && (c_addr != '1);
  assign c_own     = (c_addr == rt_addr) && (c_addr != '1);

  // R1: a command for another terminal leaves the block idle and silent
  a_r1_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && c_foreign) |=> (!busy && !status_req && !data_req && !mode_cmd && !bcast_cmd));

  // R3: a transmit data command answers with status first
  a_r3_status_first: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && c_own && c_x && !c_mode) |=> (status_req && busy && !data_req));

  // R5: no status word while a broadcast command is current
  a_r5_bcast_silent: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_cmd |-> !status_req);

  // R6: mode code to own address answers at once without a transfer
  a_r6_mode_answer: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && c_own && c_mode) |=> (status_req && mode_cmd && !busy));

  // R9: no request can start from idle without a command
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_valid) |=> (!status_req && !data_req));

  // R3: the two requests never coincide
  a_r3_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({status_req, data_req}));
endmodule

bind rt_responder rt_responder_chk #(
  .ADDR_W_P(ADDR_W_P), .SUB_W_P(SUB_W_P), .CNT_W_P(CNT_W_P)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .rt_addr   (rt_addr),
  .cmd_word  (cmd_word),
  .cmd_valid (cmd_valid),
  .status_req(status_req),
  .data_req  (data_req),
  .mode_cmd  (mode_cmd),
  .bcast_cmd (bcast_cmd),
  .busy      (busy)
);

// File: tb/rt_responder_tb_top.sv
`timescale 1ns/1ps
module rt_responder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rt_addr = 5'd9;
  logic [15:0] cmd_word = '0;
  logic        cmd_valid = 1'b0, data_valid = 1'b0, tx_done = 1'b0;
  logic        status_req, data_req, mode_cmd, bcast_cmd, busy;

  always #2.5 clk = ~clk;

  rt_responder dut_i (
    .clk(clk), .rst_n(rst_n), .rt_addr(rt_addr), .cmd_word(cmd_word),
    .cmd_valid(cmd_valid), .data_valid(data_valid), .tx_done(tx_done),
    .status_req(status_req), .data_req(data_req), .mode_cmd(mode_cmd),
    .bcast_cmd(bcast_cmd), .busy(busy)
  );

  localparam logic [4:0] OWN = 5'd9, OTHER = 5'd12, BC = 5'd31;

  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  bit mon_en = 1'b0, done = 1'b0;

  typedef struct { int at; logic [1:0] kind; string req; } exp_t;
  exp_t sb[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(input logic [1:0] kind, input string req);
    exp_t e;
    e.at = cyc + 1; e.kind = kind; e.req = req;
    sb.push_back(e);
  endtask

  // Monitor: kind 2 = status_req, kind 1 = data_req
  always @(negedge clk) begin
    if (mon_en) begin
      logic [1:0] obs;
      obs = {status_req, data_req};
      if (sb.size() > 0 && sb[0].at == cyc) begin
        exp_t e;
        e = sb.pop_front();
        chk(obs == e.kind, e.req, int'(obs), int'(e.kind));
      end else if (obs != 2'b00) begin
        chk(1'b0, "unexpected request R9", int'(obs), 0);
      end
    end
  end

  task automatic send_cmd(input logic [4:0] a, input bit x, input logic [4:0] sa,
                          input logic [4:0] n, input bit e_stat, input bit e_busy,
                          input bit e_mode, input bit e_bc, input string req);
    @(negedge clk);
    cmd_word  = {a, x, sa, n};
    cmd_valid = 1'b1;
    if (e_stat) push(2'b10, req);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == e_busy, {req, " busy"}, busy, e_busy);
    chk(mode_cmd == e_mode, {req, " mode_cmd"}, mode_cmd, e_mode);
    chk(bcast_cmd == e_bc, {req, " bcast_cmd"}, bcast_cmd, e_bc);
  endtask

  task automatic rx_word(input bit e_stat, input bit e_busy, input string req);
    @(negedge clk);
    data_valid = 1'b1;
    if (e_stat) push(2'b10, req);
    @(negedge clk);
    data_valid = 1'b0;
    chk(busy == e_busy, {req, " busy"}, busy, e_busy);
  endtask

  task automatic tx_word(input bit e_data, input bit e_busy, input string req);
    @(negedge clk);
    tx_done = 1'b1;
    if (e_data) push(2'b01, req);
    @(negedge clk);
    tx_done = 1'b0;
    chk(busy == e_busy, {req, " busy"}, busy, e_busy);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state while held
    chk({status_req, data_req, mode_cmd, bcast_cmd, busy} == 5'b0, "R8 held", busy, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({status_req, data_req, mode_cmd, bcast_cmd, busy} == 5'b0, "R8 released", busy, 0);
    mon_en = 1'b1;

    // R9: strobes in idle
    rx_word(1'b0, 1'b0, "R9 idle data");
    tx_word(1'b0, 1'b0, "R9 idle tx_done");

    // R2: receive two words, status after the second
    send_cmd(OWN, 1'b0, 5'd3, 5'd2, 1'b0, 1'b1, 1'b0, 1'b0, "R2 rx cmd");
    rx_word(1'b0, 1'b1, "R2 word1");
    tx_word(1'b0, 1'b1, "R9 tx_done in rx");
    rx_word(1'b1, 1'b0, "R2 word2 status");

    // R3: transmit three words
    send_cmd(OWN, 1'b1, 5'd5, 5'd3, 1'b1, 1'b1, 1'b0, 1'b0, "R3 tx cmd status");
    for (int i = 0; i < 3; i++) tx_word(1'b1, 1'b1, "R3 data_req");
    tx_word(1'b0, 1'b0, "R3 final");

    // R4: count 0 receives 32 words
    send_cmd(OWN, 1'b0, 5'd7, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R4 rx32 cmd");
    for (int i = 0; i < 31; i++) rx_word(1'b0, 1'b1, "R4 rx32 word");
    rx_word(1'b1, 1'b0, "R4 rx32 last");

    // R4: count 0 transmits 32 words
    send_cmd(OWN, 1'b1, 5'd7, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R4 tx32 cmd");
    for (int i = 0; i < 32; i++) tx_word(1'b1, 1'b1, "R4 tx32 data_req");
    tx_word(1'b0, 1'b0, "R4 tx32 final");

    // R5: broadcast receive, no status
    send_cmd(BC, 1'b0, 5'd4, 5'd2, 1'b0, 1'b1, 1'b0, 1'b1, "R5 bc rx cmd");
    rx_word(1'b0, 1'b1, "R5 bc word1");
    rx_word(1'b0, 1'b0, "R5 bc word2 silent");
    chk(bcast_cmd == 1'b1, "R10 bcast held", bcast_cmd, 1);
    // R5: broadcast transmit data command ignored
    send_cmd(BC, 1'b1, 5'd4, 5'd2, 1'b0, 1'b0, 1'b0, 1'b0, "R5 bc tx ignored");
    tx_word(1'b0, 1'b0, "R5 bc tx no data");

    // R6: mode codes
    send_cmd(OWN, 1'b1, 5'd0, 5'd2, 1'b1, 1'b0, 1'b1, 1'b0, "R6 mode sa0");
    send_cmd(OWN, 1'b0, 5'd31, 5'd17, 1'b1, 1'b0, 1'b1, 1'b0, "R6 mode sa31");
    rx_word(1'b0, 1'b0, "R6 no data counted");
    send_cmd(BC, 1'b1, 5'd0, 5'd1, 1'b0, 1'b0, 1'b1, 1'b1, "R6 bc mode silent");

    // R1: foreign address ignored
    send_cmd(OTHER, 1'b0, 5'd3, 5'd2, 1'b0, 1'b0, 1'b0, 1'b0, "R1 foreign");
    rx_word(1'b0, 1'b0, "R1 foreign data");
    rx_word(1'b0, 1'b0, "R1 foreign data2");

    // R7: abort a receive by a transmit command
    send_cmd(OWN, 1'b0, 5'd3, 5'd4, 1'b0, 1'b1, 1'b0, 1'b0, "R7 rx cmd");
    rx_word(1'b0, 1'b1, "R7 word1");
    rx_word(1'b0, 1'b1, "R7 word2");
    send_cmd(OWN, 1'b1, 5'd6, 5'd1, 1'b1, 1'b1, 1'b0, 1'b0, "R7 new tx cmd");
    tx_word(1'b1, 1'b1, "R7 data_req");
    tx_word(1'b0, 1'b0, "R7 tx final");
    rx_word(1'b0, 1'b0, "R7 old rx dead");
    rx_word(1'b0, 1'b0, "R7 old rx dead2");

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R3 scoreboard drained", sb.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule